// File: doc/BRIEF.md
# DRAM Bank Timing Legality Checker

This block watches the command stream sent to one rank of DDR2-style memory with eight banks and tells the command scheduler, every cycle, which commands could legally issue next. For each bank it reports separately whether an activate, a read, a write or a precharge would respect every timing interval. It also reports whether a refresh is legal. The intervals covered are the per-bank row timings, the spacing between column commands, the read/write turnaround on the shared data bus, the activate-to-activate spacing between banks and the lockout after a refresh.

The scheduler presents one command per cycle with a valid strobe, a command code and a bank number. A command counts as issued only if it is legal in that cycle. A command that is not legal is dropped from the timing state, and it sets a sticky error flag. A second sticky flag reports a refresh that came too late. All interval values are parameters. Each constraint is tracked by a down-counter that saturates at zero.

Timing convention used below: if command X issues in cycle t, then "Y at least N after X" means that Y becomes legal in cycle t+N and not before.

Top module: `dtc_timing_checker`

## Requirements
- R1: Command codes on cmd_i are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge and 5 refresh; codes 6 and 7 are never legal. After reset, every bit of act_rdy_o is 1, every bit of rd_rdy_o, wr_rdy_o and pre_rdy_o is 0, ref_rdy_o is 1, and err_o and ref_late_o are 0.
- R2: Each bank is either closed or open. An activate is legal only to a closed bank, and it opens that bank. A read, write or precharge is legal only to an open bank, and a precharge closes it. Bit b of each ready vector refers to bank b.
- R3: A read or write to a bank is legal no sooner than 5 cycles after that bank's activate.
- R4: Two reads, or two writes, to any banks are at least 4 cycles apart. This is the larger of the 2-cycle column spacing and the 4-cycle data burst.
- R5: A write is at least 5 cycles after the most recent read to any bank (read latency 5 plus burst 4 minus write latency 4), so that the data bursts never overlap.
- R6: A read is at least 11 cycles after the most recent write to any bank (write latency 4 plus burst 4 plus write-to-read delay 3).
- R7: A precharge to a bank is at least 18 cycles after its activate, at least 3 cycles after its last read, and at least 14 cycles after its last write (write latency 4 plus burst 4 plus write recovery 6).
- R8: An activate to a bank is at least 5 cycles after that bank's precharge and at least 22 cycles after that bank's previous activate.
- R9: An activate is at least 3 cycles after an activate to any bank.
- R10: Activates and refreshes are at least 51 cycles after a refresh. A refresh is legal only when every bank is closed and every bank's R8 intervals have elapsed.
- R11: A valid command that is not legal in its cycle sets err_o from the next cycle until reset. The dropped command leaves every ready output exactly as if it had not been presented.
- R12: Let t be the cycle of the last issued refresh, with reset release counting as a refresh in cycle -1. If no refresh issues in cycles t+1 through t+28000, ref_late_o rises in cycle t+28001 and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is presented this cycle |
| cmd_i | input | 3 | Command code (R1) |
| bank_i | input | 3 | Target bank of the command |
| act_rdy_o | output | 8 | Activate legal, one bit per bank |
| rd_rdy_o | output | 8 | Read legal, one bit per bank |
| wr_rdy_o | output | 8 | Write legal, one bit per bank |
| pre_rdy_o | output | 8 | Precharge legal, one bit per bank |
| ref_rdy_o | output | 1 | Refresh legal |
| err_o | output | 1 | Sticky: an illegal command was presented |
| ref_late_o | output | 1 | Sticky: the refresh interval was exceeded |

## Verification
The bench first runs a random stream that presents only legal commands. Because each command issues in the first cycle it becomes legal, every interval is hit at its exact boundary, and a timer that is off by one cycle in either direction shows up. Periodic drain-and-refresh rounds close all banks, refresh, and then retry activates at once, which exercises the refresh lockout and the all-closed refresh gate. A phase that presents any code to any bank regardless of legality shows whether rejected commands really leave the timing state untouched and whether the error flag latches. A final idle stretch longer than the refresh interval separates a correct late-refresh deadline from one that fires a cycle early or late.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } dtc_cmd_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dtc_bank_timer.sv
module dtc_bank_timer #(
  parameter int unsigned CW     = 5,
  parameter int unsigned T_RCD  = 5,
  parameter int unsigned T_RAS  = 18,
  parameter int unsigned T_RC   = 22,
  parameter int unsigned T_RP   = 5,
  parameter int unsigned T_RTP  = 3,
  parameter int unsigned WR2PRE = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic pre_i,
  output logic open_o,
  output logic col_ok_o,
  output logic pre_ok_o,
  output logic act_ok_o
);

  logic [CW-1:0] col_q, col_d;
  logic [CW-1:0] pre_q, pre_d;
  logic [CW-1:0] act_q, act_d;
  logic          open_q, open_d;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  // interval n lands at zero n cycles after the issuing cycle
  function automatic logic [CW-1:0] ld(input logic [CW-1:0] c, input int unsigned n);
    logic [CW-1:0] v;
    v = CW'(n - 1);
    return (v > c) ? v : c;
  endfunction

  always_comb begin
    col_d  = dec(col_q);
    pre_d  = dec(pre_q);
    act_d  = dec(act_q);
    open_d = open_q;
    if (act_i) begin
      col_d  = ld(col_d, T_RCD);
      pre_d  = ld(pre_d, T_RAS);
      act_d  = ld(act_d, T_RC);
      open_d = 1'b1;
    end
    if (rd_i) pre_d = ld(pre_d, T_RTP);
    if (wr_i) pre_d = ld(pre_d, WR2PRE);
    if (pre_i) begin
      act_d  = ld(act_d, T_RP);
      open_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      pre_q  <= '0;
      act_q  <= '0;
      open_q <= 1'b0;
    end else begin
      col_q  <= col_d;
      pre_q  <= pre_d;
      act_q  <= act_d;
      open_q <= open_d;
    end
  end

  assign open_o   = open_q;
  assign col_ok_o = (col_q == '0);
  assign pre_ok_o = (pre_q == '0);
  assign act_ok_o = (act_q == '0);

endmodule

// File: rtl/dtc_shared_timer.sv
module dtc_shared_timer #(
  parameter int unsigned CW     = 6,
  parameter int unsigned AW     = 15,
  parameter int unsigned C2C    = 4,
  parameter int unsigned RD2WR  = 5,
  parameter int unsigned WR2RD  = 11,
  parameter int unsigned T_RRD  = 3,
  parameter int unsigned T_RFC  = 51,
  parameter int unsigned T_REFI = 28000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic ref_i,
  output logic rd_ok_o,
  output logic wr_ok_o,
  output logic rrd_ok_o,
  output logic rfc_ok_o,
  output logic late_o
);

  logic [CW-1:0] rd_q, rd_d, wr_q, wr_d, rrd_q, rrd_d, rfc_q, rfc_d;
  logic [AW-1:0] age_q, age_d;
  logic          late_q, late_d;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  function automatic logic [CW-1:0] ld(input logic [CW-1:0] c, input int unsigned n);
    logic [CW-1:0] v;
    v = CW'(n - 1);
    return (v > c) ? v : c;
  endfunction

  always_comb begin
    rd_d  = dec(rd_q);
    wr_d  = dec(wr_q);
    rrd_d = dec(rrd_q);
    rfc_d = dec(rfc_q);
    if (rd_i) begin
      rd_d = ld(rd_d, C2C);
      wr_d = ld(wr_d, RD2WR);
    end
    if (wr_i) begin
      wr_d = ld(wr_d, C2C);
      rd_d = ld(rd_d, WR2RD);
    end
    if (act_i) rrd_d = ld(rrd_d, T_RRD);
    if (ref_i) rfc_d = ld(rfc_d, T_RFC);
  end

  // age counts cycles since last refresh; saturates at the deadline
  always_comb begin
    late_d = late_q;
    if (ref_i) begin
      age_d = '0;
    end else begin
      age_d = (age_q == AW'(T_REFI)) ? age_q : age_q + 1'b1;
      if (age_q >= AW'(T_REFI - 1)) late_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      wr_q   <= '0;
      rrd_q  <= '0;
      rfc_q  <= '0;
      age_q  <= '0;
      late_q <= 1'b0;
    end else begin
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      rrd_q  <= rrd_d;
      rfc_q  <= rfc_d;
      age_q  <= age_d;
      late_q <= late_d;
    end
  end

  assign rd_ok_o  = (rd_q == '0);
  assign wr_ok_o  = (wr_q == '0);
  assign rrd_ok_o = (rrd_q == '0);
  assign rfc_ok_o = (rfc_q == '0);
  assign late_o   = late_q;

endmodule

// File: rtl/dtc_timing_checker.sv
module dtc_timing_checker
  import dtc_pkg::*;
#(
  parameter int unsigned N_BANKS = 8,
  parameter int unsigned T_RCD   = 5,
  parameter int unsigned T_CL    = 5,
  parameter int unsigned T_WL    = 4,
  parameter int unsigned T_CCD   = 2,
  parameter int unsigned T_BURST = 4,
  parameter int unsigned T_WTR   = 3,
  parameter int unsigned T_WR    = 6,
  parameter int unsigned T_RTP   = 3,
  parameter int unsigned T_RAS   = 18,
  parameter int unsigned T_RP    = 5,
  parameter int unsigned T_RRD   = 3,
  parameter int unsigned T_RC    = 22,
  parameter int unsigned T_RFC   = 51,
  parameter int unsigned T_REFI  = 28000,
  localparam int unsigned BW     = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_i,
  input  logic [BW-1:0]      bank_i,
  output logic [N_BANKS-1:0] act_rdy_o,
  output logic [N_BANKS-1:0] rd_rdy_o,
  output logic [N_BANKS-1:0] wr_rdy_o,
  output logic [N_BANKS-1:0] pre_rdy_o,
  output logic               ref_rdy_o,
  output logic               err_o,
  output logic               ref_late_o
);

  localparam int unsigned C2C    = max2(T_CCD, T_BURST);
  localparam int unsigned RD2WR  = max2(C2C, T_CL + T_BURST - T_WL);
  localparam int unsigned WR2RD  = max2(C2C, T_WL + T_BURST + T_WTR);
  localparam int unsigned WR2PRE = T_WL + T_BURST + T_WR;
  localparam int unsigned MAX_B  = max2(max2(T_RCD, T_RAS), max2(max2(T_RC, T_RP), max2(T_RTP, WR2PRE)));
  localparam int unsigned MAX_S  = max2(max2(RD2WR, WR2RD), max2(T_RRD, T_RFC));
  localparam int unsigned BCW    = $clog2(MAX_B + 1);
  localparam int unsigned SCW    = $clog2(MAX_S + 1);
  localparam int unsigned AW     = $clog2(T_REFI + 1);

  logic [N_BANKS-1:0] bank_sel;
  logic [N_BANKS-1:0] open_v, col_ok_v, pre_ok_v, act_ok_v;
  logic               rd_ok, wr_ok, rrd_ok, rfc_ok;
  logic               legal, issue;
  logic               act_go, rd_go, wr_go, pre_go, ref_go;
  logic               err_q;

  always_comb begin
    bank_sel = '0;
    bank_sel[bank_i] = 1'b1;
  end

  always_comb begin
    case (cmd_i)
      CMD_NOP: legal = 1'b1;
      CMD_ACT: legal = act_rdy_o[bank_i];
      CMD_RD:  legal = rd_rdy_o[bank_i];
      CMD_WR:  legal = wr_rdy_o[bank_i];
      CMD_PRE: legal = pre_rdy_o[bank_i];
      CMD_REF: legal = ref_rdy_o;
      default: legal = 1'b0;
    endcase
  end

  assign issue  = cmd_valid_i & legal;
  assign act_go = issue & (cmd_i == CMD_ACT);
  assign rd_go  = issue & (cmd_i == CMD_RD);
  assign wr_go  = issue & (cmd_i == CMD_WR);
  assign pre_go = issue & (cmd_i == CMD_PRE);
  assign ref_go = issue & (cmd_i == CMD_REF);

  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    dtc_bank_timer #(
      .CW(BCW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
      .T_RP(T_RP), .T_RTP(T_RTP), .WR2PRE(WR2PRE)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (act_go & bank_sel[g]),
      .rd_i     (rd_go & bank_sel[g]),
      .wr_i     (wr_go & bank_sel[g]),
      .pre_i    (pre_go & bank_sel[g]),
      .open_o   (open_v[g]),
      .col_ok_o (col_ok_v[g]),
      .pre_ok_o (pre_ok_v[g]),
      .act_ok_o (act_ok_v[g])
    );

    assign act_rdy_o[g] = ~open_v[g] & act_ok_v[g] & rrd_ok & rfc_ok;
    assign rd_rdy_o[g]  = open_v[g] & col_ok_v[g] & rd_ok;
    assign wr_rdy_o[g]  = open_v[g] & col_ok_v[g] & wr_ok;
    assign pre_rdy_o[g] = open_v[g] & pre_ok_v[g];
  end

  dtc_shared_timer #(
    .CW(SCW), .AW(AW), .C2C(C2C), .RD2WR(RD2WR), .WR2RD(WR2RD),
    .T_RRD(T_RRD), .T_RFC(T_RFC), .T_REFI(T_REFI)
  ) u_shared (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (act_go),
    .rd_i     (rd_go),
    .wr_i     (wr_go),
    .ref_i    (ref_go),
    .rd_ok_o  (rd_ok),
    .wr_ok_o  (wr_ok),
    .rrd_ok_o (rrd_ok),
    .rfc_ok_o (rfc_ok),
    .late_o   (ref_late_o)
  );

  assign ref_rdy_o = ~(|open_v) & (&act_ok_v) & rfc_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    err_q <= 1'b0;
    else if (cmd_valid_i && !legal) err_q <= 1'b1;
  end

  assign err_o = err_q;

endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
  parameter int unsigned N_BANKS = 8,
  parameter int unsigned BW      = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cmd_valid_i,
  input logic [2:0]         cmd_i,
  input logic [BW-1:0]      bank_i,
  input logic [N_BANKS-1:0] act_rdy_o,
  input logic [N_BANKS-1:0] rd_rdy_o,
  input logic [N_BANKS-1:0] wr_rdy_o,
  input logic [N_BANKS-1:0] pre_rdy_o,
  input logic               ref_rdy_o,
  input logic               err_o,
  input logic               ref_late_o
);

  logic act_go, col_go, ref_go;
  assign act_go = cmd_valid_i && (cmd_i == 3'd1) && act_rdy_o[bank_i];
  assign col_go = cmd_valid_i && (((cmd_i == 3'd2) && rd_rdy_o[bank_i]) ||
                                  ((cmd_i == 3'd3) && wr_rdy_o[bank_i]));
  assign ref_go = cmd_valid_i && (cmd_i == 3'd5) && ref_rdy_o;

  a_r11_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r11_reject_sets_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (cmd_i == 3'd1) && !act_rdy_o[bank_i]) |=> err_o);

  a_r3_no_col_after_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_go |=> (!rd_rdy_o[$past(bank_i)] && !wr_rdy_o[$past(bank_i)]));

  a_r9_act_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_go |=> (act_rdy_o == '0));

  a_r4_cas_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_go |=> ((rd_rdy_o == '0) && (wr_rdy_o == '0)));

  a_r10_rfc_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_go |=> ((act_rdy_o == '0) && !ref_rdy_o));

  a_r2_state_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act_rdy_o & (rd_rdy_o | wr_rdy_o | pre_rdy_o)) == '0));

  a_r12_late_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_late_o |=> ref_late_o);

endmodule

bind dtc_timing_checker dtc_checker #(.N_BANKS(N_BANKS), .BW(BW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .bank_i      (bank_i),
  .act_rdy_o   (act_rdy_o),
  .rd_rdy_o    (rd_rdy_o),
  .wr_rdy_o    (wr_rdy_o),
  .pre_rdy_o   (pre_rdy_o),
  .ref_rdy_o   (ref_rdy_o),
  .err_o       (err_o),
  .ref_late_o  (ref_late_o)
);

// File: tb/sim_dtc_timing_checker.sv
`timescale 1ns/1ps
module sim_dtc_timing_checker;

  localparam int NB   = 8;
  localparam int REFI = 28000;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic [2:0]    cmd_i = 3'd0;
  logic [2:0]    bank_i = 3'd0;
  logic [NB-1:0] act_rdy_o, rd_rdy_o, wr_rdy_o, pre_rdy_o;
  logic          ref_rdy_o, err_o, ref_late_o;

  always #2.5 clk = ~clk;

  dtc_timing_checker u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .bank_i(bank_i), .act_rdy_o(act_rdy_o), .rd_rdy_o(rd_rdy_o),
    .wr_rdy_o(wr_rdy_o), .pre_rdy_o(pre_rdy_o), .ref_rdy_o(ref_rdy_o),
    .err_o(err_o), .ref_late_o(ref_late_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural model: issue times of past commands
  int now;
  int lact[NB], lpre[NB], lrd[NB], lwr[NB];
  bit opn[NB];
  int gact, grd, gwr, gref, lastref;
  bit merr, mlate;

  function automatic bit m_act(int b);
    return !opn[b] && now >= lpre[b] + 5 && now >= lact[b] + 22 &&
           now >= gact + 3 && now >= gref + 51;
  endfunction
  function automatic bit m_rd(int b);
    return opn[b] && now >= lact[b] + 5 && now >= grd + 4 && now >= gwr + 11;
  endfunction
  function automatic bit m_wr(int b);
    return opn[b] && now >= lact[b] + 5 && now >= gwr + 4 && now >= grd + 5;
  endfunction
  function automatic bit m_pre(int b);
    return opn[b] && now >= lact[b] + 18 && now >= lrd[b] + 3 && now >= lwr[b] + 14;
  endfunction
  function automatic bit m_ref();
    bit ok = (now >= gref + 51);
    for (int b = 0; b < NB; b++)
      if (opn[b] || now < lpre[b] + 5 || now < lact[b] + 22) ok = 0;
    return ok;
  endfunction
  function automatic bit m_legal(int c, int b);
    case (c)
      0: return 1;
      1: return m_act(b);
      2: return m_rd(b);
      3: return m_wr(b);
      4: return m_pre(b);
      5: return m_ref();
      default: return 0;
    endcase
  endfunction

  task automatic chk(string what, string tags, logic [NB-1:0] act, logic [NB-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual %b expected %b", tags, what, now, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [NB-1:0] ea, er, ew, ep;
    for (int b = 0; b < NB; b++) begin
      ea[b] = m_act(b); er[b] = m_rd(b); ew[b] = m_wr(b); ep[b] = m_pre(b);
    end
    chk("act_rdy", "R2 R8 R9 R10", act_rdy_o, ea);
    chk("rd_rdy",  "R2 R3 R4 R6",  rd_rdy_o,  er);
    chk("wr_rdy",  "R2 R3 R4 R5",  wr_rdy_o,  ew);
    chk("pre_rdy", "R2 R7",        pre_rdy_o, ep);
    chk("ref_rdy", "R10",          {7'd0, ref_rdy_o},  {7'd0, m_ref()});
    chk("err",     "R11",          {7'd0, err_o},      {7'd0, merr});
    chk("ref_late","R12",          {7'd0, ref_late_o}, {7'd0, mlate});
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(bit v, int c, int b);
    bit lg, refd;
    compare_all();
    lg = m_legal(c, b);
    cmd_valid_i = v; cmd_i = 3'(c); bank_i = 3'(b);
    refd = 0;
    if (v && !lg) merr = 1;
    if (v && lg) begin
      case (c)
        1: begin lact[b] = now; gact = now; opn[b] = 1; end
        2: begin lrd[b] = now; grd = now; end
        3: begin lwr[b] = now; gwr = now; end
        4: begin lpre[b] = now; opn[b] = 0; end
        5: begin gref = now; lastref = now; refd = 1; end
        default: ;
      endcase
    end
    if (!refd && now - lastref >= REFI) mlate = 1;
    @(posedge clk);
    @(negedge clk);
    now++;
  endtask

  task automatic rand_legal();
    int c = $urandom_range(1, 5);
    int b = $urandom_range(0, NB - 1);
    if (m_legal(c, b)) step(1, c, b);
    else step(bit'($urandom_range(0, 1)), 0, b);
  endtask

  task automatic drain_and_refresh();
    for (int k = 0; k < 400; k++) begin
      int pick = -1;
      bit any = 0;
      for (int b = 0; b < NB; b++) begin
        if (opn[b]) any = 1;
        if (pick < 0 && m_pre(b)) pick = b;
      end
      if (!any) break;
      if (pick >= 0) step(1, 4, pick);
      else step(0, 0, 0);
    end
    for (int k = 0; k < 400 && !m_ref(); k++) step(0, 0, 0);
    step(1, 5, 0);                          // R10 refresh issue
    for (int k = 0; k < 80; k++)            // R10 activate lockout boundary
      if (m_act(k % NB)) step(1, 1, k % NB);
      else step(1, 1, k % NB) ;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    for (int b = 0; b < NB; b++) begin
      lact[b] = -1000; lpre[b] = -1000; lrd[b] = -1000; lwr[b] = -1000; opn[b] = 0;
    end
    gact = -1000; grd = -1000; gwr = -1000; gref = -1000; lastref = -1;
    merr = 0; mlate = 0; now = 0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    chk("reset act_rdy", "R1", act_rdy_o, '1);
    chk("reset rd|wr|pre", "R1", rd_rdy_o | wr_rdy_o | pre_rdy_o, '0);
    chk("reset flags", "R1", {5'd0, ref_rdy_o, err_o, ref_late_o}, 8'b0000_0100);
    // legal-only random traffic at first-legal cycles, R3 to R10
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 2000; i++) rand_legal();
      drain_and_refresh();
    end
    // R11 arbitrary codes to arbitrary banks, illegal ones dropped
    for (int i = 0; i < 1500; i++)
      step(1, $urandom_range(0, 7), $urandom_range(0, NB - 1));
    // R12 no refresh past the deadline
    for (int i = 0; i < REFI + 100; i++) step(0, 0, 0);
    compare_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule